// File: doc/BRIEF.md
# In-Place Sequential Radix-2 FFT Engine

This block computes a complex fast Fourier transform of `2**LOG2N` points (1024 by default) through one shared butterfly unit. Every sample is one 32-bit word. The real part sits in bits 31:16 and the imaginary part in bits 15:0. Both parts are two's-complement Q1.15 values. Two independent real signals can travel together in one frame, one signal in each half of the word. Separating their spectra afterwards is left to logic outside this block.

A frame passes through three phases.

- **Load.** The engine accepts `N` words. Each word goes into the working RAM at the bit-reversed position of its arrival index.
- **Transform.** The engine runs `log2(N)` decimation-in-time stages in place, one butterfly per two clock cycles. Every stage halves its results, so the full transform is scaled by `1/N`.
- **Drain.** The engine streams the `N` spectrum bins out in natural order on consecutive cycles. It then returns to the load phase for the next frame.

Top module: `fft_engine`

## Requirements
- R1: After reset, `phase_o` is 0 (load), `in_ready` is 1 and `out_valid` is 0.
- R2: In the load phase, a word is taken only on a cycle where `in_valid` is 1. Cycles with `in_valid` low do not advance the load and leave no trace in the result. After exactly `N` accepted words, `phase_o` becomes 1 (transform) and `in_ready` drops.
- R3: Stage s (s = 0 … log2N−1) combines entries whose addresses differ only in bit s. The lower entry receives C = (A + W·B) >>> 1 and the upper entry receives D = (A − W·B) >>> 1.
- R4: In stage s, the twiddle index for butterfly offset j is j·N/2^(s+1). Twiddle W^k has real part round(32768·cos(2πk/N)) and imaginary part round(−32768·sin(2πk/N)), with halves rounded away from zero and +32768 clamped to 32767.
- R5: Each complex product is rounded to 18 bits as (P + 2^14) >>> 15, separately for the real and imaginary parts. The sum or difference is then shifted right arithmetically by one bit, and its low 16 bits are kept.
- R6: The transform phase lasts exactly N·log2N cycles. `xform_done` is 1 only during the final transform cycle.
- R7: The drain phase outputs bins 0 … N−1 in order, one per cycle, with `out_valid` held high throughout. `drain_done` is 1 together with the last bin. The next cycle is in the load phase with `in_ready` at 1.
- R8: Consecutive frames are independent. The output of a frame depends only on the `N` words accepted for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present on `in_data` |
| in_data | input | 32 | Sample word: real in bits 31:16, imaginary in bits 15:0 |
| in_ready | output | 1 | High throughout the load phase |
| out_valid | output | 1 | A spectrum bin is present on `out_data` |
| out_data | output | 32 | Spectrum bin, in the same packing as `in_data` |
| phase_o | output | 2 | 0 = load, 1 = transform, 2 = drain |
| xform_done | output | 1 | Final transform cycle |
| drain_done | output | 1 | Last bin of the frame |

## Verification
The checker module tests the following on every cycle:

- each butterfly write touches a pair of addresses that differ only in the current stage bit;
- each twiddle index lies on the grid of its stage;
- the transform phase lasts N·log2N cycles;
- the output stream runs unbroken, never overlaps the load phase, and hands back to the load phase.

The numeric results, including the product rounding, the per-stage halving and the natural output order, can only be shown by the bench. Its scoreboard compares every bin with a fixed-point model written independently, using an impulse, gapped input and a mixed pattern across back-to-back frames.

// File: rtl/fft_pkg.sv
`timescale 1ns/1ps
package fft_pkg;
  localparam int SAMP_W = 16;
  localparam int WORD_W = 2 * SAMP_W;
  localparam int PW     = 2 * SAMP_W + 1;  // full complex-product width
  localparam int QW     = SAMP_W + 2;      // rounded product width

  typedef struct packed {
    logic signed [SAMP_W-1:0] re;
    logic signed [SAMP_W-1:0] im;
  } cplx_t;

  typedef struct packed {
    logic signed [QW-1:0] re;
    logic signed [QW-1:0] im;
  } prod_t;

  typedef struct packed {
    cplx_t lo;  // written to the lower address
    cplx_t hi;  // written to the upper address
  } bfly_pair_t;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_XFORM = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  // Reverse the low w bits of v.
  function automatic logic [31:0] bit_rev(input logic [31:0] v, input int w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (i < w) r[w-1-i] = v[i];
    return r;
  endfunction

  // Round a Q2.30 accumulator back to an 18-bit Q.15 value.
  function automatic logic signed [QW-1:0] q15_round(input logic signed [PW-1:0] acc);
    logic signed [PW-1:0] t;
    t = acc + PW'(1 << (SAMP_W - 2));
    return t[SAMP_W-1 +: QW];
  endfunction

  function automatic prod_t cmul(input cplx_t b, input cplx_t w);
    logic signed [PW-1:0] br, bi, wr, wi;
    prod_t p;
    br = PW'(b.re);
    bi = PW'(b.im);
    wr = PW'(w.re);
    wi = PW'(w.im);
    p.re = q15_round(br * wr - bi * wi);
    p.im = q15_round(br * wi + bi * wr);
    return p;
  endfunction

  // One scaled radix-2 butterfly.
  function automatic bfly_pair_t butterfly(input cplx_t a, input cplx_t b, input cplx_t w);
    prod_t p;
    logic signed [QW-1:0] ar, ai, sr, si, dr, di;
    bfly_pair_t o;
    p  = cmul(b, w);
    ar = QW'(a.re);
    ai = QW'(a.im);
    sr = ar + p.re;
    si = ai + p.im;
    dr = ar - p.re;
    di = ai - p.im;
    o.lo.re = sr[SAMP_W:1];
    o.lo.im = si[SAMP_W:1];
    o.hi.re = dr[SAMP_W:1];
    o.hi.im = di[SAMP_W:1];
    return o;
  endfunction
endpackage

// File: rtl/fft_addr_gen.sv
`timescale 1ns/1ps
module fft_addr_gen #(
  parameter int LOG2N = 10
) (
  input  logic [$clog2(LOG2N)-1:0] stage,
  input  logic [LOG2N-2:0]         bidx,
  output logic [LOG2N-1:0]         addr_a,
  output logic [LOG2N-1:0]         addr_b,
  output logic [LOG2N-2:0]         tw_idx
);
  localparam int AW = LOG2N;
  localparam int SW = $clog2(LOG2N);

  logic [AW-1:0] bext, lowmask, j, hi;
  logic [SW-1:0] shamt;

  always_comb begin
    bext    = {1'b0, bidx};
    lowmask = (AW'(1) << stage) - AW'(1);
    j       = bext & lowmask;
    hi      = bext & ~lowmask;
    addr_a  = (hi << 1) | j;
    addr_b  = addr_a | (AW'(1) << stage);
    shamt   = SW'(LOG2N - 1) - stage;
    tw_idx  = (AW-1)'(j << shamt);
  end
endmodule

// File: rtl/fft_twiddle_rom.sv
`timescale 1ns/1ps
module fft_twiddle_rom
  import fft_pkg::*;
#(
  parameter int LOG2N = 10
) (
  input  logic [LOG2N-2:0] idx,
  output cplx_t            w
);
  localparam int N    = 1 << LOG2N;
  localparam int HALF = N / 2;

  logic [WORD_W-1:0] tbl [HALF];

  function automatic logic signed [SAMP_W-1:0] to_q15(input real x);
    real s;
    s = x * 32768.0;
    if (s > 32767.0) return 16'sh7FFF;
    if (s >= 0.0) return SAMP_W'($rtoi(s + 0.5));
    return SAMP_W'($rtoi(s - 0.5));
  endfunction

  initial begin
    for (int k = 0; k < HALF; k++) begin
      real ang;
      ang = 2.0 * 3.141592653589793 * real'(k) / real'(N);
      tbl[k] = {to_q15($cos(ang)), to_q15(-$sin(ang))};
    end
  end

  assign w = tbl[idx];
endmodule

// File: rtl/fft_engine.sv
`timescale 1ns/1ps
module fft_engine
  import fft_pkg::*;
#(
  parameter int LOG2N = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic [1:0]  phase_o,
  output logic        xform_done,
  output logic        drain_done
);
  localparam int N  = 1 << LOG2N;
  localparam int AW = LOG2N;
  localparam int SW = $clog2(LOG2N);

  phase_t          st;
  logic [AW-1:0]   cnt;
  logic [SW-1:0]   stage;
  logic [AW-2:0]   bidx;
  logic            ph;
  logic [WORD_W-1:0] ram [N];

  logic [AW-1:0]   addr_a, addr_b;
  logic [AW-2:0]   tw_idx;
  cplx_t           tw, opa, opb, opw;
  bfly_pair_t      res;

  // Named internal events
  logic ev_load, ev_rd, ev_wr, ev_stage_end, ev_xform_end, ev_drain, ev_drain_end;

  fft_addr_gen #(.LOG2N(LOG2N)) u_ag (
    .stage (stage),
    .bidx  (bidx),
    .addr_a(addr_a),
    .addr_b(addr_b),
    .tw_idx(tw_idx)
  );

  fft_twiddle_rom #(.LOG2N(LOG2N)) u_rom (
    .idx(tw_idx),
    .w  (tw)
  );

  always_comb begin
    ev_load      = (st == PH_LOAD) && in_valid;
    ev_rd        = (st == PH_XFORM) && !ph;
    ev_wr        = (st == PH_XFORM) && ph;
    ev_stage_end = ev_wr && (bidx == '1);
    ev_xform_end = ev_stage_end && (stage == SW'(LOG2N - 1));
    ev_drain     = (st == PH_DRAIN);
    ev_drain_end = ev_drain && (cnt == '1);
    res          = butterfly(opa, opb, opw);
  end

  assign in_ready   = (st == PH_LOAD);
  assign phase_o    = st;
  assign xform_done = ev_xform_end;

  // Working RAM: the load port and the butterfly write-back share it
  always_ff @(posedge clk) begin
    if (ev_load)
      ram[AW'(bit_rev(32'(cnt), LOG2N))] <= in_data;
    else if (ev_wr) begin
      ram[addr_a] <= res.lo;
      ram[addr_b] <= res.hi;
    end
  end

  // Operand capture (first cycle of each butterfly)
  always_ff @(posedge clk) begin
    if (ev_rd) begin
      opa <= ram[addr_a];
      opb <= ram[addr_b];
      opw <= tw;
    end
  end

  // Output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      drain_done <= 1'b0;
      out_data   <= '0;
    end else begin
      out_valid  <= ev_drain;
      drain_done <= ev_drain_end;
      if (ev_drain) out_data <= ram[cnt];
    end
  end

  // Controller
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PH_LOAD;
      cnt   <= '0;
      stage <= '0;
      bidx  <= '0;
      ph    <= 1'b0;
    end else begin
      unique case (st)
        PH_LOAD: if (ev_load) begin
          cnt <= cnt + AW'(1);
          if (cnt == '1) st <= PH_XFORM;
        end
        PH_XFORM: begin
          ph <= ~ph;
          if (ev_wr) begin
            bidx <= bidx + 1'b1;
            if (ev_stage_end) stage <= stage + SW'(1);
            if (ev_xform_end) begin
              stage <= '0;
              st    <= PH_DRAIN;
            end
          end
        end
        PH_DRAIN: begin
          cnt <= cnt + AW'(1);
          if (ev_drain_end) st <= PH_LOAD;
        end
        default: st <= PH_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/fft_engine_chk.sv
`timescale 1ns/1ps
module fft_engine_chk #(
  parameter int LOG2N = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               phase,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     xform_done,
  input logic                     drain_done,
  input logic                     ev_wr,
  input logic [LOG2N-1:0]         addr_a,
  input logic [LOG2N-1:0]         addr_b,
  input logic [LOG2N-2:0]         tw_idx,
  input logic [$clog2(LOG2N)-1:0] stage
);
  localparam int N  = 1 << LOG2N;
  localparam int AW = LOG2N;

  logic [31:0] xcnt;
  always_ff @(posedge clk) begin
    if (!rst_n)              xcnt <= '0;
    else if (phase == 2'd1)  xcnt <= xcnt + 32'd1;
    else                     xcnt <= '0;
  end

  a_r3_pair_span: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> (((addr_a ^ addr_b) == (AW'(1) << stage)) && !addr_a[stage]));

  a_r4_tw_grid: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> (((32'(tw_idx) << (32'(stage) + 32'd1)) & 32'(N - 1)) == 32'd0));

  a_r6_xform_len: assert property (@(posedge clk) disable iff (!rst_n)
    xform_done |-> (xcnt == 32'(N * LOG2N - 1)));

  a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xform_done, drain_done}));

  a_r7_stream_run: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !drain_done) |=> out_valid);

  a_r7_back_to_load: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> in_ready);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid && !drain_done));
endmodule

bind fft_engine fft_engine_chk #(.LOG2N(LOG2N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase_o),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .xform_done(xform_done),
  .drain_done(drain_done),
  .ev_wr     (ev_wr),
  .addr_a    (addr_a),
  .addr_b    (addr_b),
  .tw_idx    (tw_idx),
  .stage     (stage)
);

// File: tb/fft_engine_tb.sv
`timescale 1ns/1ps
module fft_engine_tb;
  localparam int L = 4;
  localparam int N = 1 << L;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, xform_done, drain_done;
  logic [31:0] out_data;
  logic [1:0]  phase_o;

  int checks = 0;
  int fails  = 0;
  int nout   = 0;
  int sre [N];
  int sim [N];
  logic [31:0] expq [$];

  always #2.5 clk = ~clk;

  fft_engine #(.LOG2N(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .phase_o(phase_o), .xform_done(xform_done), .drain_done(drain_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint wrap16(input longint v);
    longint t;
    t = v & 64'hFFFF;
    if (t >= 32768) t = t - 65536;
    return t;
  endfunction

  function automatic longint tq(input real x);
    longint r;
    r = longint'(x * 32768.0);
    if (r > 32767) r = 32767;
    return r;
  endfunction

  // Independent fixed-point model (R3, R4, R5): fills the scoreboard queue
  task automatic push_expected();
    longint xr [N];
    longint xi [N];
    for (int k = 0; k < N; k++) begin
      int rk = 0;
      for (int b = 0; b < L; b++) if ((k >> b) & 1) rk = rk | (1 << (L - 1 - b));
      xr[rk] = sre[k];
      xi[rk] = sim[k];
    end
    for (int s = 0; s < L; s++) begin
      int span = 1 << s;
      for (int g = 0; g < N; g += 2 * span)
        for (int j = 0; j < span; j++) begin
          int t = j * (N / (2 * span));
          real ang = 2.0 * 3.141592653589793 * real'(t) / real'(N);
          longint c = tq($cos(ang));
          longint sn = tq(-$sin(ang));
          int p = g + j;
          int q = p + span;
          longint pr = (xr[q] * c - xi[q] * sn + 16384) >>> 15;
          longint pi = (xr[q] * sn + xi[q] * c + 16384) >>> 15;
          longint ar = xr[p];
          longint ai = xi[p];
          xr[p] = wrap16((ar + pr) >>> 1);
          xi[p] = wrap16((ai + pi) >>> 1);
          xr[q] = wrap16((ar - pr) >>> 1);
          xi[q] = wrap16((ai - pi) >>> 1);
        end
    end
    for (int k = 0; k < N; k++) expq.push_back({16'(xr[k]), 16'(xi[k])});
  endtask

  // Monitor: compare each bin as it appears (R3, R5, R7)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      nout++;
      if (expq.size() == 0) chk(1'b0, "R7 unexpected bin", out_data, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(out_data == e, "R3/R5 bin value", out_data, e);
      end
    end
  end

  task automatic run_frame(input bit gaps);
    int xc;
    bit xd_ok;
    nout = 0;
    push_expected();
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      if (gaps && (k % 3 == 1)) begin
        in_valid = 1'b0;          // R2: gap cycle with junk data
        in_data  = 32'hDEAD_BEEF;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = {16'(sre[k]), 16'(sim[k])};
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 32'h1234_5678;
    chk(in_ready == 1'b0, "R2 ready drops after N words", 32'(in_ready), 32'd0);
    xc = 0;
    xd_ok = 1'b1;
    while (phase_o == 2'd1 && xc < 4 * N * L) begin
      xc++;
      if (xform_done != (xc == N * L)) xd_ok = 1'b0;
      @(negedge clk);
    end
    chk(xc == N * L, "R6 transform length", 32'(xc), 32'(N * L));
    chk(xd_ok, "R6 done pulse placement", 32'(xd_ok), 32'd1);
    for (int w = 0; w < 4 * N && !drain_done; w++) @(negedge clk);
    chk(drain_done == 1'b1, "R7 drain_done with last bin", 32'(drain_done), 32'd1);
    chk(in_ready == 1'b1, "R7 load phase after drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    chk(nout == N, "R7 bin count", 32'(nout), 32'(N));
    chk(expq.size() == 0, "R7 scoreboard drained", 32'(expq.size()), 32'd0);
    chk(out_valid == 1'b0, "R7 stream ends", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(phase_o == 2'd0, "R1 reset phase", 32'(phase_o), 32'd0);
    chk(in_ready == 1'b1, "R1 reset ready", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;

    // Impulse (R3, R4, R5)
    for (int k = 0; k < N; k++) begin sre[k] = 0; sim[k] = 0; end
    sre[0] = 4000;
    run_frame(1'b0);

    // Two real signals with gapped input (R2, R8)
    for (int k = 0; k < N; k++) begin
      sre[k] = k * 200 - 1500;
      sim[k] = (k % 2 == 0) ? 1000 : -1000;
    end
    run_frame(1'b1);

    // Mixed pattern, back to back (R8)
    for (int k = 0; k < N; k++) begin
      sre[k] = ((k * 37) % 61 - 30) * 100;
      sim[k] = ((k * 11) % 23 - 11) * 150;
    end
    run_frame(1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule